// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with a parameterised number of independent down-counting channels. Each channel owns a window of three word registers: control, interval and current count. A channel counts down once per divided tick. The divided tick comes from one of four external tick strobes, chosen per channel and then divided by a power of two. When a count runs out, the channel either reloads from its interval and keeps going (periodic) or stops and clears its own enable (one-shot).

Every expiry sets a sticky status bit. Software clears a status bit by writing a one to it. A shared mask register decides which status bits drive the single interrupt line. The bus port is a plain single-cycle port: a write takes effect on the clock edge where select and write-enable are both high, and read data is a combinational function of the address.

Stopping a channel is not instant. The channel keeps counting for a fixed number of its selected source ticks after software clears the enable bit, as a clock-domain synchroniser would. Starting a channel, and a one-shot self-stop, take effect at once.

Top module: `cdt_top`

## Requirements
- R1: While reset is asserted on a clock edge, every register returns to zero: the mask, the status, and each channel's control, interval and count. The interrupt output is low after that edge.
- R2: The byte offsets are fixed:
  - 0x00 is the interrupt mask, where bit n belongs to channel n.
  - 0x04 is the status register.
  - Channel n uses 0x10*n+0x10 for control, 0x10*n+0x14 for interval and 0x10*n+0x18 for count.
  - Any other offset reads as zero, and writes to it are ignored.
- R3: The control register fields are:
  - bit 0: enable.
  - bit 1: load request. It always reads back as 0.
  - bits 3:2: source select s, which picks tick input s.
  - bits 6:4: prescale code p.
  - bit 7: one-shot when 1, periodic when 0.
  - All other bits read as zero. Only a control write can start a channel.
- R4: A control write with bit 1 set copies the interval register into the count in that same edge. A write with bits 1 and 0 both set therefore loads the count and starts it.
- R5: A running channel decrements its count by exactly one on every 2^p-th tick of its selected source. The first such tick is counted from the starting write. Ticks on other sources have no effect.
- R6: On a divided tick where the count is 1 (or 0), the channel expires. Its status bit is set. In periodic mode the count reloads from the interval and keeps running, so the period is the interval value in divided ticks.
- R7: When a one-shot channel expires, it leaves the count at 0, clears its enable bit and stops. Later ticks do not change the count.
- R8: After a control write that clears enable on a running channel, the channel keeps counting through exactly 2 more ticks of its selected source, then holds its count.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. If an expiry and a clearing write hit the same bit in the same edge, the bit stays set.
- R10: A status bit is set even when its mask bit is 0. The interrupt output is high exactly when some channel has both its status bit and its mask bit set.
- R11: The count register is read-only: a write to its offset changes nothing.
- R12: Channels are independent. Writes, ticks and expiries on one channel leave the others' counts and status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| src_tick | input | 4 | One-cycle tick strobes of the four selectable sources |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker watches the following on every cycle:
- Each expiry lands in its status bit on the next edge.
- A running counter steps down by exactly one on a non-expiring divided tick.
- A stopped counter holds its value unless the control register is written.
- A one-shot expiry leaves the channel stopped, with enable cleared and the count at zero.
- A channel only starts through a control write.
- The interrupt only rises after an expiry or a mask change.

Some behaviour is only visible through the bench's scenarios:
- Each register lives at its stated offset.
- The count takes exactly 2^p source ticks per step, and the first divided tick falls where the starting write puts it.
- A disable lets exactly two more source ticks through.
- A set beats a clear in the same cycle.
- Reset clears a live interrupt.

// File: rtl/cdt_pkg.sv
// Package: shared field layout and constants of the down-counting timer.
// Assumes a control register of 8 meaningful bits and four tick sources.
package cdt_pkg;
    localparam int SRC_FW  = 2;               // source select field width
    localparam int PRE_FW  = 3;               // prescale code field width
    localparam int NUM_SRC = 1 << SRC_FW;     // selectable tick sources
    localparam int CTL_W   = 8;               // meaningful control bits

    localparam int BIT_RUN  = 0;
    localparam int BIT_LOAD = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_PRE  = 4;
    localparam int BIT_ONCE = 7;

    localparam int OFS_MASK   = 'h00;
    localparam int OFS_STAT   = 'h04;
    localparam int WIN_BASE   = 'h10;
    localparam int WIN_STRIDE = 'h10;
    localparam int SLOT_CTL   = 'h0;
    localparam int SLOT_IVL   = 'h4;
    localparam int SLOT_CNT   = 'h8;

    typedef struct packed {
        logic              once;
        logic [PRE_FW-1:0] pre;
        logic [SRC_FW-1:0] src;
        logic              run;
    } ctl_t;

    // Build the software view of a control register; the load bit reads 0.
    function automatic logic [CTL_W-1:0] ctl_view(input ctl_t c);
        return {c.once, c.pre, c.src, 1'b0, c.run};
    endfunction
endpackage

// File: rtl/cdt_prescale.sv
// Module: picks one tick source and divides it by 2^pre.
// Assumes the tick inputs are one-cycle strobes in the clk domain.
// The phase counter only advances while the channel runs, and clr restarts it.
module cdt_prescale
    import cdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SRC_FW-1:0]  sel,
    input  logic [PRE_FW-1:0]  pre,
    input  logic               clr,
    input  logic               run,
    output logic               src_hit,
    output logic               div_hit
);
    localparam int DIV_W = (1 << PRE_FW) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   pow2;
    logic [DIV_W-1:0] mask;

    // Compute the selected strobe and the divided pulse.
    always_comb begin
        src_hit = src_tick[sel];
        pow2    = (DIV_W+1)'(1) << pre;
        mask    = DIV_W'(pow2 - (DIV_W+1)'(1));
        div_hit = run && src_hit && ((phase_q & mask) == mask);
    end

    // Advance the divider phase on each selected tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (clr)
            phase_q <= '0;
        else if (run && src_hit)
            phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/cdt_channel.sv
// Module: one down-counting channel with its control, interval and count.
// Assumes at most one register write per cycle. A control write takes
// priority over counting in its own cycle. A stop request takes effect
// after SYNC_TICKS selected source ticks, while start and one-shot stop
// take effect at once.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               ivl_we,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [CTL_W-1:0]   ctl_rd,
    output logic [CNT_W-1:0]   ivl_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               expire,
    output logic               run_q,
    output logic               en_bit,
    output logic               once_bit,
    output logic               tick_now
);
    localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

    ctl_t              ctl_q;
    logic              pend_q;
    logic [SYNC_W-1:0] scnt_q;
    logic              start, load, src_hit, at_end, sync_done;

    // Decode this cycle's control write and the expiry condition.
    always_comb begin
        start     = ctl_we && wdata[BIT_RUN];
        load      = ctl_we && wdata[BIT_LOAD];
        at_end    = (cnt_q[CNT_W-1:1] == '0);
        expire    = run_q && tick_now && at_end && !ctl_we;
        sync_done = pend_q && src_hit && (scnt_q == SYNC_W'(SYNC_TICKS - 1));
        ctl_rd    = ctl_view(ctl_q);
        en_bit    = ctl_q.run;
        once_bit  = ctl_q.once;
    end

    cdt_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .sel      (ctl_q.src),
        .pre      (ctl_q.pre),
        .clr      (start || load),
        .run      (run_q),
        .src_hit  (src_hit),
        .div_hit  (tick_now)
    );

    // Hold the control fields; a one-shot expiry drops the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (ctl_we)
            ctl_q <= '{once: wdata[BIT_ONCE],
                       pre:  wdata[BIT_PRE +: PRE_FW],
                       src:  wdata[BIT_SRC +: SRC_FW],
                       run:  wdata[BIT_RUN]};
        else if (expire && ctl_q.once)
            ctl_q.run <= 1'b0;
    end

    // Hold the interval value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_q <= '0;
        else if (ivl_we)
            ivl_q <= wdata;
    end

    // Load, reload, or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= ivl_q;
        else if (expire)
            cnt_q <= ctl_q.once ? '0 : ivl_q;
        else if (run_q && tick_now && !ctl_we)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Track the effective run state and the deferred stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            scnt_q <= '0;
        end else if (ctl_we) begin
            scnt_q <= '0;
            if (start) begin
                run_q  <= 1'b1;
                pend_q <= 1'b0;
            end else if (run_q) begin
                pend_q <= 1'b1;
            end
        end else if (expire && ctl_q.once) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            scnt_q <= '0;
        end else if (sync_done) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            scnt_q <= '0;
        end else if (pend_q && src_hit) begin
            scnt_q <= scnt_q + SYNC_W'(1);
        end
    end
endmodule

// File: rtl/cdt_top.sv
// Module: register decode, status and interrupt logic around NUM_CH channels.
// Assumes word-aligned byte offsets and a single-cycle bus. Reads are
// combinational from the address. CNT_W must exceed 8 and be at least NUM_CH.
module cdt_top
    import cdt_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int SYNC_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               irq
);
    logic                             wr;
    logic [NUM_CH-1:0]                ien_q, sts_q, clr_mask;
    logic [NUM_CH-1:0]                exp_v, run_v, en_v, os_v, div_v, cwe_v, iwe_v;
    logic [NUM_CH-1:0][CNT_W-1:0]     cnt_v, ivl_v;
    logic [NUM_CH-1:0][CTL_W-1:0]     ctl_v;

    // Qualify the bus write strobe.
    assign wr = bus_sel && bus_we;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = WIN_BASE + WIN_STRIDE * g;

        assign cwe_v[g] = wr && (bus_addr == ADDR_W'(BASE + SLOT_CTL));
        assign iwe_v[g] = wr && (bus_addr == ADDR_W'(BASE + SLOT_IVL));

        cdt_channel #(
            .CNT_W      (CNT_W),
            .SYNC_TICKS (SYNC_TICKS)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   (cwe_v[g]),
            .ivl_we   (iwe_v[g]),
            .wdata    (bus_wdata),
            .src_tick (src_tick),
            .ctl_rd   (ctl_v[g]),
            .ivl_q    (ivl_v[g]),
            .cnt_q    (cnt_v[g]),
            .expire   (exp_v[g]),
            .run_q    (run_v[g]),
            .en_bit   (en_v[g]),
            .once_bit (os_v[g]),
            .tick_now (div_v[g])
        );
    end

    // Hold the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (wr && bus_addr == ADDR_W'(OFS_MASK))
            ien_q <= bus_wdata[NUM_CH-1:0];
    end

    // Write-one-to-clear status, where a new expiry wins over a clear.
    always_comb clr_mask = (wr && bus_addr == ADDR_W'(OFS_STAT)) ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~clr_mask) | exp_v;
    end

    // Combine masked status into the interrupt line.
    assign irq = |(sts_q & ien_q);

    // Select read data by offset; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_MASK))
            bus_rdata = CNT_W'(ien_q);
        else if (bus_addr == ADDR_W'(OFS_STAT))
            bus_rdata = CNT_W'(sts_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(WIN_BASE + WIN_STRIDE * i + SLOT_CTL))
                bus_rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_v[i]};
            else if (bus_addr == ADDR_W'(WIN_BASE + WIN_STRIDE * i + SLOT_IVL))
                bus_rdata = ivl_v[i];
            else if (bus_addr == ADDR_W'(WIN_BASE + WIN_STRIDE * i + SLOT_CNT))
                bus_rdata = cnt_v[i];
        end
    end
endmodule

// File: rtl/cdt_checker.sv
// Module: temporal checks on the timer, bound into cdt_top.
// Assumes the synchronous active-low reset of the host.
module cdt_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ien_q,
    input logic [NUM_CH-1:0]            sts_q,
    input logic [NUM_CH-1:0]            exp_v,
    input logic [NUM_CH-1:0]            run_v,
    input logic [NUM_CH-1:0]            en_v,
    input logic [NUM_CH-1:0]            os_v,
    input logic [NUM_CH-1:0]            div_v,
    input logic [NUM_CH-1:0]            cwe_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R6: an expiry is recorded in status on the next edge
        p_sts_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            exp_v[i] |=> sts_q[i]);

        // R7: a one-shot expiry stops the channel with count 0 and enable clear
        p_once_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            exp_v[i] && os_v[i] |=> !run_v[i] && !en_v[i] && cnt_v[i] == '0);

        // R5: a non-expiring divided tick steps the count down by one
        p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
            run_v[i] && div_v[i] && !cwe_v[i] && !exp_v[i]
            |=> cnt_v[i] == $past(cnt_v[i]) - CNT_W'(1));

        // R8: a stopped channel holds its count without a control write
        p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !run_v[i] && !cwe_v[i] |=> $stable(cnt_v[i]));

        // R3: counting only begins through a control write
        p_start_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_v[i]) |-> $past(cwe_v[i]));
    end

    // R10: the interrupt only rises after an expiry or a mask change
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|exp_v) || (ien_q != $past(ien_q)));
endmodule

bind cdt_top cdt_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .ien_q (ien_q),
    .sts_q (sts_q),
    .exp_v (exp_v),
    .run_v (run_v),
    .en_v  (en_v),
    .os_v  (os_v),
    .div_v (div_v),
    .cwe_v (cwe_v),
    .cnt_v (cnt_v)
);

// File: tb/tb_cdt_top.sv
// Bench: a vector table walked by one loop, then directed scenarios.
module tb_cdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    cdt_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .irq       (irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

    // For OP_TK: addr is the tick count and data is the source mask.
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{OP_RD, 8'h00, 32'h0,  32'h0, 4'd1},   // R1 mask clear after reset
        '{OP_RD, 8'h18, 32'h0,  32'h0, 4'd1},   // R1 count clear after reset
        '{OP_WR, 8'h14, 32'h5,  32'h0, 4'd2},
        '{OP_RD, 8'h14, 32'h0,  32'h5, 4'd2},   // R2 interval offset
        '{OP_WR, 8'h10, 32'h3,  32'h0, 4'd4},   // start with load, src0, p0
        '{OP_RD, 8'h18, 32'h0,  32'h5, 4'd4},   // R4 load copies interval
        '{OP_RD, 8'h10, 32'h0,  32'h1, 4'd3},   // R3 load bit reads 0
        '{OP_TK, 8'd2,  32'h1,  32'h0, 4'd5},
        '{OP_RD, 8'h18, 32'h0,  32'h3, 4'd5},   // R5 one step per tick
        '{OP_TK, 8'd3,  32'h2,  32'h0, 4'd5},
        '{OP_RD, 8'h18, 32'h0,  32'h3, 4'd5},   // R5 other source ignored
        '{OP_TK, 8'd3,  32'h1,  32'h0, 4'd6},
        '{OP_RD, 8'h18, 32'h0,  32'h5, 4'd6},   // R6 periodic reload
        '{OP_RD, 8'h04, 32'h0,  32'h1, 4'd6},   // R6 status set
        '{OP_WR, 8'h04, 32'h0,  32'h0, 4'd9},
        '{OP_RD, 8'h04, 32'h0,  32'h1, 4'd9},   // R9 write 0 keeps bit
        '{OP_WR, 8'h04, 32'h1,  32'h0, 4'd9},
        '{OP_RD, 8'h04, 32'h0,  32'h0, 4'd9},   // R9 write 1 clears bit
        '{OP_WR, 8'h18, 32'h77, 32'h0, 4'd11},
        '{OP_RD, 8'h18, 32'h0,  32'h5, 4'd11},  // R11 count is read-only
        '{OP_RD, 8'h08, 32'h0,  32'h0, 4'd2},   // R2 unmapped reads zero
        '{OP_RD, 8'h1C, 32'h0,  32'h0, 4'd2}    // R2 unmapped slot in window
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tick(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = m;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            case (TBL[v].op)
                OP_WR: wr(TBL[v].addr, TBL[v].data);
                OP_RD: rd_chk($sformatf("R%0d table row %0d", TBL[v].req, v),
                              TBL[v].addr, TBL[v].exp);
                default: tick(TBL[v].data[3:0], int'(TBL[v].addr));
            endcase
        end

        // R10: status sets with mask off, irq follows mask and clear
        tick(4'h1, 5);
        rd_chk("R10 status set while masked", 8'h04, 32'h1);
        #1 chk("R10 irq low while masked", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h1);
        #1 chk("R10 irq after unmask", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h1);
        #1 chk("R10 irq after clear", {31'b0, irq}, 32'h0);

        // R8: two more source ticks after a disable, then hold
        wr(8'h14, 32'd50);
        wr(8'h10, 32'h3);
        rd_chk("R4 reload on restart", 8'h18, 32'd50);
        wr(8'h10, 32'h0);
        rd_chk("R8 enable reads clear at once", 8'h10, 32'h0);
        tick(4'h1, 4);
        rd_chk("R8 stopped after two ticks", 8'h18, 32'd48);
        tick(4'h1, 3);
        rd_chk("R8 count holds once stopped", 8'h18, 32'd48);

        // R5: prescale code 2 on source 1 in channel 1
        wr(8'h24, 32'd100);
        wr(8'h20, 32'h27);
        rd_chk("R3 control readback", 8'h20, 32'h25);
        tick(4'h2, 8);
        rd_chk("R5 divide by four", 8'h28, 32'd98);
        tick(4'h1, 8);
        rd_chk("R12 foreign source ignored", 8'h28, 32'd98);
        tick(4'h2, 3);
        rd_chk("R5 no step before phase end", 8'h28, 32'd98);
        tick(4'h2, 1);
        rd_chk("R5 step on fourth tick", 8'h28, 32'd97);

        // R7: one-shot expiry
        wr(8'h24, 32'd3);
        wr(8'h20, 32'h87);
        tick(4'h2, 3);
        rd_chk("R7 count ends at zero", 8'h28, 32'h0);
        rd_chk("R7 enable self-clears", 8'h20, 32'h84);
        rd_chk("R7 status bit 1 set", 8'h04, 32'h2);
        tick(4'h2, 4);
        rd_chk("R7 count stays zero", 8'h28, 32'h0);

        // R9: expiry in the same edge as a clearing write wins
        wr(8'h04, 32'h2);
        rd_chk("R9 clear bit 1", 8'h04, 32'h0);
        wr(8'h24, 32'd1);
        wr(8'h20, 32'h87);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h2; src_tick = 4'h2;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; src_tick = '0;
        rd_chk("R9 set beats clear", 8'h04, 32'h2);
        rd_chk("R12 channel 0 untouched", 8'h18, 32'd48);

        // R1: reset clears live state and a pending interrupt
        wr(8'h00, 32'h2);
        #1 chk("R10 irq from channel 1", {31'b0, irq}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 chk("R1 irq low in reset", {31'b0, irq}, 32'h0);
        rd_chk("R1 status cleared", 8'h04, 32'h0);
        rd_chk("R1 control cleared", 8'h20, 32'h0);
        rd_chk("R1 interval cleared", 8'h24, 32'h0);
        rd_chk("R1 count cleared", 8'h18, 32'h0);
        rst_n = 1'b1;
        rd_chk("R1 mask cleared", 8'h00, 32'h0);

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end
endmodule